// File: doc/BRIEF.md
# Strobe-Handshake FIFO

This block is a 64-word first-in first-out buffer. Its word width is a parameter, either 4 or 5 bits. A two-phase level handshake drives it. The writer places a word on the input bus and raises a shift-in strobe. The buffer takes the word and lowers input-ready. When the writer drops the strobe, the word is committed, and input-ready comes back unless the buffer is now full. On the read side, a registered head word sits on the output bus, qualified by output-ready. Raising shift-out withdraws output-ready. Dropping shift-out retires the head word, and the next stored word is then presented.

Both strobes pass through two-flop synchronisers into the block clock, so all of the logic is synchronous. An active-low asynchronous reset acts as the master reset. An active-low output enable gates the data bus to zero without touching the flags. The block also defines its behaviour at three boundaries: a full buffer with shift-in held high, an empty buffer with shift-out held high, and reset released while shift-in is high.

Top module: `strobe_fifo`

## Requirements
- R1: While reset is low, and after it is released, input-ready is 1, output-ready is 0 and the data bus reads 0. Any stored words are discarded.
- R2: Raising shift-in while input-ready is 1 captures the input word and lowers input-ready. Lowering shift-in commits the word, and input-ready returns to 1 when fewer than 64 words are stored.
- R3: Words leave in the order they were written, across a complete fill of 64 words and the drain that follows.
- R4: With 64 words stored, input-ready stays 0. A shift-in pulse in that state stores nothing.
- R5: If shift-in is held high while the buffer is full, the pending word is taken as soon as a word is read out. Input-ready stays 0 until shift-in falls, and stays 0 afterwards because the buffer is full again.
- R6: A high shift-out lowers output-ready. Lowering shift-out retires the head word, and output-ready returns to 1 with the next word if one is stored.
- R7: While output-ready is 1, the data word does not change. A new word is only presented after output-ready has been 0 for at least one cycle.
- R8: When the last word has been read, output-ready stays 0 and the data bus keeps showing that last word.
- R9: A word written into an empty buffer, with shift-out low, raises output-ready on the fifth rising clock edge after shift-in falls at the port.
- R10: If shift-out is held high while the buffer is empty and a word is written, output-ready is 1 for exactly one cycle and then 0. That word stays on the bus, and later words wait until shift-out falls.
- R11: If shift-in is high when reset is released, the input word is stored. Input-ready is 0 until shift-in falls.
- R12: A 1 on the output-enable input forces the data bus to 0 and leaves output-ready unchanged. A 0 shows the head word.
- R13: A write commit and a read retire that fall in the same cycle leave the stored count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Master reset, asynchronous, active low |
| shift_in_i | input | 1 | Write strobe (asynchronous level) |
| data_i | input | WIDTH | Word to write |
| in_ready_o | output | 1 | High when a new word may be written |
| shift_out_i | input | 1 | Read strobe (asynchronous level) |
| out_ready_o | output | 1 | High when data_o holds a valid word |
| out_en_ni | input | 1 | Output enable, active low; high forces data_o to 0 |
| data_o | output | WIDTH | Head word |

## Verification
Each strobe change at the port reaches the control logic on the second rising edge and acts on the third. Input-ready therefore moves on the third edge after shift-in changes. Output-ready drops on the third edge after shift-out rises. A fresh head word, with output-ready, appears on the fifth edge after the strobe fall that made it available. The bench drives and samples on falling edges. It counts those edges exactly where a requirement names a latency (R2, R9, R10), and it polls with a bound only where the order of events, and not the cycle, is the requirement.

// File: rtl/strobe_fifo_pkg.sv
package strobe_fifo_pkg;
  localparam int unsigned SF_DEPTH       = 64;
  localparam int unsigned SF_WIDTH       = 5;
  localparam int unsigned SF_SYNC_STAGES = 2;
endpackage

// File: rtl/sf_sync.sv
module sf_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], async_i};
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/sf_ram.sv
module sf_ram #(
  parameter int unsigned WIDTH = 5,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/strobe_fifo.sv
module strobe_fifo
  import strobe_fifo_pkg::*;
#(
  parameter int unsigned WIDTH = SF_WIDTH,
  parameter int unsigned DEPTH = SF_DEPTH
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_in_i,
  input  logic [WIDTH-1:0] data_i,
  output logic             in_ready_o,
  input  logic             shift_out_i,
  output logic             out_ready_o,
  input  logic             out_en_ni,
  output logic [WIDTH-1:0] data_o
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic             si_s, so_s;
  logic             wr_pend_q, rd_pend_q, head_vld_q, ld_busy_q;
  logic [AW-1:0]    wptr_q, rptr_q;
  logic [CW-1:0]    count_q;
  logic [WIDTH-1:0] head_q, rdata;
  logic             full, empty, cap, commit, take, retire, ld_go;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  sf_sync #(.STAGES(SF_SYNC_STAGES)) u_si_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(shift_in_i), .sync_o(si_s)
  );
  sf_sync #(.STAGES(SF_SYNC_STAGES)) u_so_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(shift_out_i), .sync_o(so_s)
  );

  sf_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_ram (
    .clk_i(clk_i), .we_i(cap), .waddr_i(wptr_q), .wdata_i(data_i),
    .raddr_i(rptr_q), .rdata_o(rdata)
  );

  assign full   = (count_q == CW'(DEPTH));
  assign empty  = (count_q == '0);
  // level-sampled: covers fresh rise, held-high at full release and at reset release
  assign cap    = si_s & ~wr_pend_q & ~full;
  assign commit = wr_pend_q & ~si_s;
  assign take   = so_s & head_vld_q;
  assign retire = rd_pend_q & ~so_s;
  assign ld_go  = ~head_vld_q & ~rd_pend_q & ~ld_busy_q & ~empty;

  // write side
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_pend_q <= 1'b0;
      wptr_q    <= '0;
    end else begin
      if (cap)         wr_pend_q <= 1'b1;
      else if (commit) wr_pend_q <= 1'b0;
      if (commit)      wptr_q    <= ptr_inc(wptr_q);
    end
  end

  // occupancy, head word included
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) count_q <= '0;
    else         count_q <= count_q + CW'(commit) - CW'(retire);
  end

  // read side: two-clock fetch into the head register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_pend_q  <= 1'b0;
      head_vld_q <= 1'b0;
      ld_busy_q  <= 1'b0;
      rptr_q     <= '0;
      head_q     <= '0;
    end else begin
      ld_busy_q <= ld_go;
      if (take)        rd_pend_q <= 1'b1;
      else if (retire) rd_pend_q <= 1'b0;
      if (retire)      rptr_q    <= ptr_inc(rptr_q);
      if (ld_busy_q) begin
        head_vld_q <= 1'b1;
        head_q     <= rdata;
      end else if (take) begin
        head_vld_q <= 1'b0;
      end
    end
  end

  assign in_ready_o  = ~wr_pend_q & ~full;
  assign out_ready_o = head_vld_q;
  assign data_o      = out_en_ni ? '0 : head_q;

  p_capture_drop_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (si_s && in_ready_o) |=> !in_ready_o);

  p_no_overflow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full && !retire) |=> $stable(wptr_q));

  p_ready_withdraw_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (so_s && out_ready_o) |=> !out_ready_o);

  p_word_stable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_ready_o |=> $stable(head_q));

  p_empty_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty |-> !out_ready_o);
endmodule

// File: tb/strobe_fifo_bench.sv
module strobe_fifo_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 5;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         shift_in = 1'b0;
  logic [W-1:0] din = '0;
  logic         in_ready;
  logic         shift_out = 1'b0;
  logic         out_ready;
  logic         oe_n = 1'b0;
  logic [W-1:0] dout;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  strobe_fifo #(.WIDTH(W), .DEPTH(64)) u_strobe_fifo (
    .clk_i(clk), .rst_ni(rst_ni), .shift_in_i(shift_in), .data_i(din),
    .in_ready_o(in_ready), .shift_out_i(shift_out), .out_ready_o(out_ready),
    .out_en_ni(oe_n), .data_o(dout)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_ir(input logic v, input string req);
    int n;
    for (n = 0; n < 100 && in_ready !== v; n++) @(negedge clk);
    if (in_ready !== v) chk(req, "in_ready timeout", in_ready, v);
  endtask

  task automatic wait_or(input logic v, input string req);
    int n;
    for (n = 0; n < 100 && out_ready !== v; n++) @(negedge clk);
    if (out_ready !== v) chk(req, "out_ready timeout", out_ready, v);
  endtask

  task automatic push(input logic [W-1:0] w);
    wait_ir(1'b1, "R2");
    din = w;
    shift_in = 1'b1;
    wait_ir(1'b0, "R2");
    @(negedge clk);
    shift_in = 1'b0;
  endtask

  task automatic pop(input logic [W-1:0] exp, input string req);
    wait_or(1'b1, req);
    chk(req, "head word", dout, exp);
    shift_out = 1'b1;
    wait_or(1'b0, "R6");
    @(negedge clk);
    shift_out = 1'b0;
  endtask

  function automatic logic [W-1:0] pat(input int i);
    return W'((i * 7 + 3) % 32);
  endfunction

  task automatic t_reset_state;
    chk("R1", "in_ready after reset", in_ready, 1'b1);
    chk("R1", "out_ready after reset", out_ready, 1'b0);
    chk("R1", "data after reset", dout, '0);
  endtask

  task automatic t_latency;
    din = 5'h0A;
    shift_in = 1'b1;
    wait_ir(1'b0, "R2");
    @(negedge clk);
    shift_in = 1'b0;
    repeat (3) @(negedge clk);
    chk("R2", "in_ready back after commit", in_ready, 1'b1);
    chk("R9", "out_ready at edge 3", out_ready, 1'b0);
    @(negedge clk);
    chk("R9", "out_ready at edge 4", out_ready, 1'b0);
    @(negedge clk);
    chk("R9", "out_ready at edge 5", out_ready, 1'b1);
    chk("R9", "word at edge 5", dout, 5'h0A);
    pop(5'h0A, "R6");
    repeat (8) @(negedge clk);
    chk("R8", "out_ready when empty", out_ready, 1'b0);
    chk("R8", "last word kept", dout, 5'h0A);
  endtask

  task automatic t_full;
    for (int i = 0; i < 63; i++) push(pat(i));
    wait_ir(1'b1, "R2");
    din = pat(63);
    shift_in = 1'b1;
    repeat (6) @(negedge clk);
    shift_in = 1'b0;
    repeat (6) @(negedge clk);
    chk("R4", "in_ready when full", in_ready, 1'b0);
    din = 5'h15;
    shift_in = 1'b1;
    repeat (8) @(negedge clk);
    shift_in = 1'b0;
    repeat (8) @(negedge clk);
    chk("R4", "in_ready after ignored pulse", in_ready, 1'b0);
    din = 5'h1E;
    shift_in = 1'b1;
    repeat (4) @(negedge clk);
    pop(pat(0), "R3");
    repeat (8) @(negedge clk);
    chk("R5", "in_ready low while pending", in_ready, 1'b0);
    shift_in = 1'b0;
    repeat (8) @(negedge clk);
    chk("R5", "in_ready low when full again", in_ready, 1'b0);
    for (int i = 1; i < 64; i++) pop(pat(i), "R3");
    pop(5'h1E, "R5");
    repeat (8) @(negedge clk);
    chk("R8", "out_ready after drain", out_ready, 1'b0);
    chk("R8", "last word after drain", dout, 5'h1E);
    chk("R4", "in_ready after drain", in_ready, 1'b1);
  endtask

  task automatic t_held_out;
    shift_out = 1'b1;
    repeat (4) @(negedge clk);
    din = 5'h11;
    shift_in = 1'b1;
    wait_ir(1'b0, "R2");
    @(negedge clk);
    shift_in = 1'b0;
    repeat (4) @(negedge clk);
    chk("R10", "out_ready before pulse", out_ready, 1'b0);
    @(negedge clk);
    chk("R10", "out_ready pulse", out_ready, 1'b1);
    @(negedge clk);
    chk("R10", "out_ready after pulse", out_ready, 1'b0);
    chk("R10", "word held", dout, 5'h11);
    push(5'h12);
    repeat (10) @(negedge clk);
    chk("R10", "queued word hidden", out_ready, 1'b0);
    chk("R10", "first word still shown", dout, 5'h11);
    shift_out = 1'b0;
    pop(5'h12, "R10");
    repeat (8) @(negedge clk);
    chk("R10", "empty after queue", out_ready, 1'b0);
  endtask

  task automatic t_concurrent;
    push(5'h01);
    push(5'h02);
    wait_or(1'b1, "R13");
    wait_ir(1'b1, "R13");
    din = 5'h03;
    shift_in = 1'b1;
    shift_out = 1'b1;
    wait_ir(1'b0, "R13");
    wait_or(1'b0, "R13");
    @(negedge clk);
    shift_in = 1'b0;
    shift_out = 1'b0;
    pop(5'h02, "R13");
    pop(5'h03, "R13");
    repeat (8) @(negedge clk);
    chk("R13", "empty after concurrent", out_ready, 1'b0);
    chk("R13", "in_ready after concurrent", in_ready, 1'b1);
  endtask

  task automatic t_out_enable;
    push(5'h17);
    wait_or(1'b1, "R12");
    oe_n = 1'b1;
    @(negedge clk);
    chk("R12", "bus gated", dout, '0);
    chk("R12", "flag kept", out_ready, 1'b1);
    oe_n = 1'b0;
    @(negedge clk);
    chk("R12", "bus restored", dout, 5'h17);
    pop(5'h17, "R12");
  endtask

  task automatic t_reset_held_in;
    push(5'h09);
    wait_or(1'b1, "R1");
    din = 5'h1C;
    shift_in = 1'b1;
    rst_ni = 1'b0;
    @(negedge clk);
    chk("R1", "in_ready in reset", in_ready, 1'b1);
    chk("R1", "out_ready in reset", out_ready, 1'b0);
    chk("R1", "bus in reset", dout, '0);
    rst_ni = 1'b1;
    repeat (6) @(negedge clk);
    chk("R11", "in_ready low after release", in_ready, 1'b0);
    shift_in = 1'b0;
    pop(5'h1C, "R11");
    chk("R11", "in_ready after fall", in_ready, 1'b1);
    repeat (8) @(negedge clk);
    chk("R1", "old word discarded", out_ready, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_latency();
    t_full();
    t_held_out();
    t_concurrent();
    t_out_enable();
    t_reset_held_in();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL all watchdog actual=expired expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule